// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the coherence and control logic for one processor's small direct-mapped, write-back data cache. Each line holds one data word and sits in one of three states: Invalid (no data), Shared (clean, readable, other copies may exist) or Exclusive (the only copy, writable and dirty). The processor issues one read or write at a time and waits for a ready pulse. Hits complete locally. Every miss, and every write to a line that is not Exclusive, goes to the shared bus. The controller first requests the bus and waits for the grant. Only then does it issue a writeback of a dirty victim, if there is one, followed by a read-miss or write-miss command.

The controller also watches the commands that other caches put on the bus. A snooped read miss that hits a local Exclusive line makes the controller supply the dirty word to memory and drop the line to Shared. A snooped write miss that hits a local copy invalidates it, and a dirty copy is supplied to memory first. Snoop events take priority over new processor requests. A snoop that arrives while the controller is still waiting for its grant changes the line state, and the controller decides on a writeback only at the moment the grant arrives.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset, every line is Invalid, bus_req and cpu_ready are low, bus_cmd is 0 (no command) and sup_valid is low.
- R2: A processor read whose address hits a Shared or Exclusive line returns the line's word with cpu_ready high in the cycle after the request is taken, and puts nothing on the bus.
- R3: A processor write that hits an Exclusive line updates its word with no bus request and no bus command.
- R4: A processor write to a line that is Shared or Invalid, or that holds another tag, issues a write-miss command (bus_cmd 2) on the written address. When bus_done arrives, the line becomes Exclusive and holds the written word.
- R5: A processor read miss issues a read-miss command (bus_cmd 1) on the address. It fills the line as Shared with bus_rdata and returns that word.
- R6: bus_req stays high from the miss until the transaction ends. No bus command is driven, and the line is not changed for the miss, before bus_gnt is high.
- R7: A snooped read miss (snp_cmd 1) that hits a local Exclusive line raises sup_valid one cycle later, with the line's address and word, and leaves the line Shared. A later local write to that line then needs the bus.
- R8: A snooped write miss (snp_cmd 2) that hits a local line moves it to Invalid. If the line was Exclusive, its word is supplied first on the sup_ ports. The next local access to the line misses.
- R9: A miss to an index whose line is Exclusive with another tag first issues a writeback (bus_cmd 3) with the victim's address and word, and then the miss command. A Shared victim is dropped without a writeback.
- R10: The need for a writeback is judged when the grant arrives. A victim that a snoop downgraded while the request waited is not written back.
- R11: When a snooped write miss to the same block comes in while a local write waits for the grant, the local write still completes after the grant. Its value is the one later supplied for the block.
- R12: cpu_ready is a single-cycle pulse, and only one processor request is in progress at a time.
- R13: A snoop and a local line update never take place in the same cycle, and a snoop never makes a line Exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held while bus_req is high |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 writeback |
| bus_addr | output | ADDR_W | Address of the command |
| bus_wdata | output | DATA_W | Writeback word |
| bus_done | input | 1 | One-cycle completion of the current command |
| bus_rdata | input | DATA_W | Fill word, valid with bus_done |
| snp_valid | input | 1 | Another master's command is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| sup_valid | output | 1 | Dirty word supplied to memory |
| sup_addr | output | ADDR_W | Address of the supplied word |
| sup_data | output | DATA_W | Supplied word |

## Verification
Some rules are checked by the assertions on every cycle. A bus command needs both a grant and a request. A pending request stays up until it is granted. A writeback is always followed by a miss command. The ready signal is a single-cycle pulse. A supply only follows a snoop. Snoop and local updates never collide, and a snoop never grants ownership. Other behaviour shows only in the bench's scenarios, which compare the traffic against a line-state model. This covers data values and the exact command sequence per access: no traffic on hits, writeback plus miss on a dirty conflict, and a bare miss for a Shared victim. It also covers the two waiting-for-grant cases, where a victim is downgraded before the grant and where a competing write invalidates the line before the grant.

// File: rtl/cc_pkg.sv
// Shared types for the snooping cache controller.
// Assumes: line states and bus command codes are fixed 2-bit encodings.
package cc_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHD = 2'd1,
        LS_EXC = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_RDMISS = 2'd1,
        CMD_WRMISS = 2'd2,
        CMD_WB     = 2'd3
    } bus_cmd_e;
endpackage

// File: rtl/cc_line_store.sv
// Line storage: state, tag and one data word per direct-mapped line.
// Two read ports (processor lookup, snoop lookup), one controller write
// port and one snoop state-update port. Snoop update wins on a collision,
// which the environment never produces.
module cc_line_store
    import cc_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cpu_idx,
    output line_state_e       cpu_state,
    output logic [TAG_W-1:0]  cpu_tag,
    output logic [DATA_W-1:0] cpu_data,
    input  logic [IDX_W-1:0]  snp_idx,
    output line_state_e       snp_state,
    output logic [TAG_W-1:0]  snp_tag,
    output logic [DATA_W-1:0] snp_data,
    input  logic              ctl_we,
    input  logic [IDX_W-1:0]  ctl_idx,
    input  line_state_e       ctl_state,
    input  logic [TAG_W-1:0]  ctl_tag,
    input  logic              ctl_data_we,
    input  logic [DATA_W-1:0] ctl_data,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_upd_idx,
    input  line_state_e       snp_upd_state
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0][1:0]        st_q;
    logic [LINES-1:0][TAG_W-1:0]  tag_q;
    logic [LINES-1:0][DATA_W-1:0] dat_q;

    // Line states: reset to Invalid, snoop update has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (snp_we && snp_upd_idx == IDX_W'(i))
                    st_q[i] <= snp_upd_state;
                else if (ctl_we && ctl_idx == IDX_W'(i))
                    st_q[i] <= ctl_state;
            end
        end
    end

    // Tags and data words: written only by the controller.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (ctl_we && ctl_idx == IDX_W'(i)) begin
                tag_q[i] <= ctl_tag;
                if (ctl_data_we)
                    dat_q[i] <= ctl_data;
            end
        end
    end

    assign cpu_state = line_state_e'(st_q[cpu_idx]);
    assign cpu_tag   = tag_q[cpu_idx];
    assign cpu_data  = dat_q[cpu_idx];
    assign snp_state = line_state_e'(st_q[snp_idx]);
    assign snp_tag   = tag_q[snp_idx];
    assign snp_data  = dat_q[snp_idx];

    // R13: snoop and controller never update lines in the same cycle
    assert_single_writer_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_we && ctl_we));

    // R13: a snoop only ever lowers a line, never grants ownership
    assert_snoop_no_own_R13: assert property (@(posedge clk) disable iff (!rst_n)
        snp_we |-> (snp_upd_state != LS_EXC));
endmodule

// File: rtl/cc_snoop.sv
// Snoop responder: looks up the snooped address, decides the new line
// state, and registers a supply of the dirty word when the line is
// Exclusive. Assumes snp_valid is never high while this cache owns the bus.
module cc_snoop
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  look_idx,
    input  line_state_e       look_state,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [DATA_W-1:0] look_data,
    output logic              upd_we,
    output line_state_e       upd_state,
    output logic              sup_valid,
    output logic [ADDR_W-1:0] sup_addr,
    output logic [DATA_W-1:0] sup_data
);
    logic tag_hit;
    logic supply;

    assign look_idx = snp_addr[IDX_W-1:0];
    assign tag_hit  = (look_state != LS_INV) && (look_tag == snp_addr[ADDR_W-1:IDX_W]);

    // Decide the new state of the snooped line and whether to supply data.
    always_comb begin
        upd_we    = 1'b0;
        upd_state = look_state;
        supply    = 1'b0;
        if (snp_valid && tag_hit) begin
            if (snp_cmd == CMD_WRMISS) begin
                upd_we    = 1'b1;
                upd_state = LS_INV;
                supply    = (look_state == LS_EXC);
            end else if (snp_cmd == CMD_RDMISS && look_state == LS_EXC) begin
                upd_we    = 1'b1;
                upd_state = LS_SHD;
                supply    = 1'b1;
            end
        end
    end

    // Supply register: valid pulse plus captured address and dirty word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_valid <= 1'b0;
            sup_addr  <= '0;
            sup_data  <= '0;
        end else begin
            sup_valid <= supply;
            if (supply) begin
                sup_addr <= snp_addr;
                sup_data <= look_data;
            end
        end
    end

    // R7: a supply is always the answer to a snoop one cycle earlier
    assert_supply_after_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sup_valid |-> ($past(snp_valid) && sup_addr == $past(snp_addr)));
endmodule

// File: rtl/cc_ctrl_fsm.sv
// Processor-side controller: lookup, hit handling, bus arbitration and
// the writeback / miss sequence. One request in flight at a time.
// Assumes the arbiter holds bus_gnt while bus_req is high and drives no
// snoop while granting this cache.
module cc_ctrl_fsm
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    output logic [IDX_W-1:0]  lk_idx,
    input  line_state_e       lk_state,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              ctl_we,
    output line_state_e       ctl_state,
    output logic [TAG_W-1:0]  ctl_tag,
    output logic              ctl_data_we,
    output logic [DATA_W-1:0] ctl_data
);
    typedef enum logic [2:0] {ST_IDLE, ST_ARB, ST_WB, ST_MISS, ST_DONE} ctl_st_e;

    ctl_st_e            st_q, st_d;
    logic               op_we_q;
    logic [ADDR_W-1:0]  op_addr_q;
    logic [DATA_W-1:0]  op_wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [TAG_W-1:0]   in_tag;
    logic               tag_eq;
    logic               accept;
    logic               rd_hit;

    assign accept = (st_q == ST_IDLE) && cpu_req && !snp_valid;
    assign lk_idx = (st_q == ST_IDLE) ? cpu_addr[IDX_W-1:0] : op_addr_q[IDX_W-1:0];
    assign in_tag = (st_q == ST_IDLE) ? cpu_addr[ADDR_W-1:IDX_W] : op_addr_q[ADDR_W-1:IDX_W];
    assign tag_eq = (lk_tag == in_tag);
    assign rd_hit = !cpu_we && lk_state != LS_INV && tag_eq;

    // Next state and line-update requests for each phase.
    always_comb begin
        st_d        = st_q;
        ctl_we      = 1'b0;
        ctl_data_we = 1'b0;
        ctl_state   = lk_state;
        ctl_tag     = lk_tag;
        ctl_data    = op_wdata_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (rd_hit) begin
                        st_d = ST_DONE;
                    end else if (cpu_we && lk_state == LS_EXC && tag_eq) begin
                        st_d        = ST_DONE;
                        ctl_we      = 1'b1;
                        ctl_data_we = 1'b1;
                        ctl_data    = cpu_wdata;
                    end else begin
                        st_d = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                if (bus_gnt)
                    st_d = (lk_state == LS_EXC && !tag_eq) ? ST_WB : ST_MISS;
            end
            ST_WB: begin
                if (bus_done) begin
                    ctl_we    = 1'b1;
                    ctl_state = LS_INV;
                    st_d      = ST_MISS;
                end
            end
            ST_MISS: begin
                if (bus_done) begin
                    ctl_we      = 1'b1;
                    ctl_data_we = 1'b1;
                    ctl_tag     = op_addr_q[ADDR_W-1:IDX_W];
                    ctl_state   = op_we_q ? LS_EXC : LS_SHD;
                    ctl_data    = op_we_q ? op_wdata_q : bus_rdata;
                    st_d        = ST_DONE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture the accepted request and the word returned to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_we_q    <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
            rdata_q    <= '0;
        end else begin
            if (accept) begin
                op_we_q    <= cpu_we;
                op_addr_q  <= cpu_addr;
                op_wdata_q <= cpu_wdata;
                if (rd_hit) rdata_q <= lk_data;
            end
            if (st_q == ST_MISS && bus_done && !op_we_q)
                rdata_q <= bus_rdata;
        end
    end

    // Bus-side outputs decoded from the phase.
    always_comb begin
        bus_req   = (st_q == ST_ARB) || (st_q == ST_WB) || (st_q == ST_MISS);
        bus_cmd   = CMD_NONE;
        bus_addr  = op_addr_q;
        bus_wdata = op_wdata_q;
        if (st_q == ST_WB) begin
            bus_cmd   = CMD_WB;
            bus_addr  = {lk_tag, op_addr_q[IDX_W-1:0]};
            bus_wdata = lk_data;
        end else if (st_q == ST_MISS) begin
            bus_cmd = op_we_q ? CMD_WRMISS : CMD_RDMISS;
        end
    end

    assign cpu_ready = (st_q == ST_DONE);
    assign cpu_rdata = rdata_q;

    // R6: a command on the bus needs the grant and our own request
    assert_cmd_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != CMD_NONE) |-> (bus_gnt && bus_req));

    // R6: a pending request is held until the arbiter grants it
    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R9: a finished writeback is followed directly by the miss command
    assert_wb_then_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_WB && bus_done) |=> (bus_cmd == CMD_RDMISS || bus_cmd == CMD_WRMISS));

    // R12: completion is a single-cycle pulse
    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
endmodule

// File: rtl/snoop_cache_ctrl.sv
// Top of the snooping write-invalidate cache controller: wires the line
// store, the snoop responder and the processor-side controller.
// Assumes one-word lines, direct mapping, and an external arbiter and
// memory that follow the bus rules given in the brief.
module snoop_cache_ctrl
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sup_valid,
    output logic [ADDR_W-1:0] sup_addr,
    output logic [DATA_W-1:0] sup_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx, sn_idx;
    line_state_e       lk_state, sn_state, ctl_state, sn_upd_state;
    logic [TAG_W-1:0]  lk_tag, sn_tag, ctl_tag;
    logic [DATA_W-1:0] lk_data, sn_data, ctl_data;
    logic              ctl_we, ctl_data_we, sn_upd_we;

    cc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_idx       (lk_idx),
        .cpu_state     (lk_state),
        .cpu_tag       (lk_tag),
        .cpu_data      (lk_data),
        .snp_idx       (sn_idx),
        .snp_state     (sn_state),
        .snp_tag       (sn_tag),
        .snp_data      (sn_data),
        .ctl_we        (ctl_we),
        .ctl_idx       (lk_idx),
        .ctl_state     (ctl_state),
        .ctl_tag       (ctl_tag),
        .ctl_data_we   (ctl_data_we),
        .ctl_data      (ctl_data),
        .snp_we        (sn_upd_we),
        .snp_upd_idx   (sn_idx),
        .snp_upd_state (sn_upd_state)
    );

    cc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
        .clk        (clk),
        .rst_n      (rst_n),
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_addr   (snp_addr),
        .look_idx   (sn_idx),
        .look_state (sn_state),
        .look_tag   (sn_tag),
        .look_data  (sn_data),
        .upd_we     (sn_upd_we),
        .upd_state  (sn_upd_state),
        .sup_valid  (sup_valid),
        .sup_addr   (sup_addr),
        .sup_data   (sup_data)
    );

    cc_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .cpu_ready   (cpu_ready),
        .bus_req     (bus_req),
        .bus_gnt     (bus_gnt),
        .bus_cmd     (bus_cmd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_done    (bus_done),
        .bus_rdata   (bus_rdata),
        .snp_valid   (snp_valid),
        .lk_idx      (lk_idx),
        .lk_state    (lk_state),
        .lk_tag      (lk_tag),
        .lk_data     (lk_data),
        .ctl_we      (ctl_we),
        .ctl_state   (ctl_state),
        .ctl_tag     (ctl_tag),
        .ctl_data_we (ctl_data_we),
        .ctl_data    (ctl_data)
    );
endmodule

// File: tb/sim_snoop_cache_ctrl.sv
// Bench: behavioural arbiter, memory and "other caches" around one
// controller; expected traffic and data from a line-state model.
module sim_snoop_cache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_done = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        sup_valid;
    logic [7:0]  sup_addr;
    logic [15:0] sup_data;

    int          checks = 0, errors = 0;
    logic [15:0] mem [256];
    logic [15:0] golden [256];
    int          mst [4];
    int          mtag [4];
    int          log_cmd [8], log_addr [8], log_data [8];
    int          log_n = 0;
    int          sup_cnt = 0, sup_a = 0, sup_d = 0;
    bit          gnt_block = 1'b0;
    logic [15:0] rd_val;

    always #5 clk = ~clk;

    snoop_cache_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .sup_valid(sup_valid), .sup_addr(sup_addr), .sup_data(sup_data)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Arbiter: grants a pending request after a random wait unless blocked.
    initial begin
        forever begin
            @(negedge clk);
            if (!bus_req) bus_gnt = 1'b0;
            else if (!gnt_block && $urandom_range(0, 1) == 1) bus_gnt = 1'b1;
        end
    end

    // Memory responder: logs commands, answers them, absorbs supplied words.
    initial begin
        forever begin
            @(negedge clk);
            bus_done = 1'b0;
            if (sup_valid) begin
                mem[sup_addr] = sup_data;
                sup_cnt++;
                sup_a = int'(sup_addr);
                sup_d = int'(sup_data);
            end
            if (rst_n && bus_cmd != 2'd0) begin
                if (log_n < 8) begin
                    log_cmd[log_n]  = int'(bus_cmd);
                    log_addr[log_n] = int'(bus_addr);
                    log_data[log_n] = int'(bus_wdata);
                end
                log_n++;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
                bus_rdata = mem[bus_addr];
                bus_done  = 1'b1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    task automatic cpu_op(input bit we, input int a, input logic [15:0] d, output logic [15:0] r);
        @(negedge clk);
        log_n     = 0;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = 8'(a);
        cpu_wdata = d;
        do @(negedge clk); while (!cpu_ready);
        r       = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_ready, "R12", "ready pulse width", int'(cpu_ready), 0);
    endtask

    // Another cache's access seen through the snoop port; checks supply.
    task automatic other_access(input bit we, input int a, input logic [15:0] v);
        int  idx = a % 4;
        int  tg  = a / 4;
        bit  hit = (mst[idx] != 0) && (mtag[idx] == tg);
        bit  dirty = hit && (mst[idx] == 2);
        int  s0 = sup_cnt;
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = we ? 2'd2 : 2'd1;
        snp_addr  = 8'(a);
        @(negedge clk);
        snp_valid = 1'b0;
        @(negedge clk);
        chk((sup_cnt - s0) == (dirty ? 1 : 0), we ? "R8" : "R7", "supply count", sup_cnt - s0, dirty ? 1 : 0);
        if (dirty) begin
            chk(sup_a == a, we ? "R8" : "R7", "supply address", sup_a, a);
            chk(sup_d == int'(golden[a]), we ? "R8" : "R7", "supply word", sup_d, int'(golden[a]));
        end
        chk(mem[a] == golden[a], "R7", "memory coherent after snoop", int'(mem[a]), int'(golden[a]));
        if (we) begin
            if (hit) mst[idx] = 0;
            golden[a] = v;
            mem[a]    = v;
        end else if (dirty) begin
            mst[idx] = 1;
        end
    endtask

    // Processor access with expected traffic computed from the line model.
    task automatic do_cpu(input bit we, input int a, input logic [15:0] d);
        int    idx = a % 4;
        int    tg  = a / 4;
        int    vic = mtag[idx] * 4 + idx;
        bit    hit = we ? (mst[idx] == 2 && mtag[idx] == tg) : (mst[idx] != 0 && mtag[idx] == tg);
        bit    wb  = !hit && mst[idx] == 2 && mtag[idx] != tg;
        int    mc  = we ? 2 : 1;
        string rq  = hit ? (we ? "R3" : "R2") : (we ? "R4" : "R5");
        logic [15:0] r;
        cpu_op(we, a, d, r);
        if (hit) begin
            chk(log_n == 0, rq, "no bus traffic on hit", log_n, 0);
        end else if (wb) begin
            chk(log_n == 2, "R9", "command count with dirty victim", log_n, 2);
            chk(log_cmd[0] == 3 && log_addr[0] == vic, "R9", "writeback first, victim address", log_addr[0], vic);
            chk(log_data[0] == int'(golden[vic]), "R9", "writeback word", log_data[0], int'(golden[vic]));
            chk(log_cmd[1] == mc && log_addr[1] == a, rq, "miss command after writeback", log_cmd[1], mc);
        end else begin
            chk(log_n == 1, rq, "single miss command", log_n, 1);
            chk(log_cmd[0] == mc && log_addr[0] == a, rq, "miss command and address", log_cmd[0], mc);
        end
        if (!we) chk(r == golden[a], rq, "read word", int'(r), int'(golden[a]));
        else     golden[a] = d;
        mst[idx]  = we ? 2 : 1;
        mtag[idx] = tg;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 16'((i * 37 + 5) & 16'hFFFF);
            golden[i] = mem[i];
        end
        for (int i = 0; i < 4; i++) begin
            mst[i]  = 0;
            mtag[i] = 0;
        end
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!bus_req && bus_cmd == 2'd0, "R1", "bus idle in reset", int'(bus_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && bus_cmd == 2'd0, "R1", "bus idle after reset", int'(bus_cmd), 0);
        chk(!cpu_ready && !sup_valid, "R1", "ready and supply low", int'(cpu_ready), 0);
        do_cpu(1'b0, 3, 16'h0);   // R1: first read misses, all lines Invalid

        // R5, R2: miss then hit on the same line
        do_cpu(1'b0, 1, 16'h0);
        do_cpu(1'b0, 1, 16'h0);
        // R4: write to a Shared line goes to the bus, then R3 hit
        do_cpu(1'b1, 1, 16'hA001);
        do_cpu(1'b1, 1, 16'hA002);
        // R9: conflicting read forces writeback of the dirty word
        do_cpu(1'b0, 5, 16'h0);
        // R9: Shared victim dropped without writeback
        do_cpu(1'b0, 9, 16'h0);

        // R10: victim downgraded by a snoop while the miss waits for grant
        do_cpu(1'b1, 4, 16'hC0DE);
        gnt_block = 1'b1;
        fork
            cpu_op(1'b0, 8, 16'h0, rd_val);
            begin
                repeat (4) @(negedge clk);
                chk(bus_req && bus_cmd == 2'd0, "R6", "request pending, no command before grant", int'(bus_cmd), 0);
                other_access(1'b0, 4, 16'h0);
                gnt_block = 1'b0;
            end
        join
        chk(log_n == 1 && log_cmd[0] == 1 && log_addr[0] == 8, "R10", "no writeback for downgraded victim", log_n, 1);
        chk(rd_val == golden[8], "R10", "read word after grant", int'(rd_val), int'(golden[8]));
        mst[0] = 1; mtag[0] = 2;

        // R11: competing write invalidates the line before our grant
        do_cpu(1'b0, 5, 16'h0);
        gnt_block = 1'b1;
        fork
            cpu_op(1'b1, 5, 16'hBEEF, rd_val);
            begin
                repeat (4) @(negedge clk);
                other_access(1'b1, 5, 16'h1234);
                gnt_block = 1'b0;
            end
        join
        chk(log_n == 1 && log_cmd[0] == 2 && log_addr[0] == 5, "R11", "write miss after losing the line", log_cmd[0], 2);
        golden[5] = 16'hBEEF; mst[1] = 2; mtag[1] = 1;
        other_access(1'b0, 5, 16'h0);   // R11, R7: our value is the one supplied
        do_cpu(1'b1, 5, 16'hBEF0);      // R7: line is Shared now, write needs the bus

        // R8: snooped write miss on an Exclusive line, then a reload
        do_cpu(1'b1, 6, 16'h5151);
        other_access(1'b1, 6, 16'h7777);
        do_cpu(1'b0, 6, 16'h0);

        // Random mix of local and remote accesses over 16 addresses.
        for (int n = 0; n < 400; n++) begin
            int sel = $urandom_range(0, 99);
            int a   = $urandom_range(0, 15);
            logic [15:0] v = 16'($urandom);
            if (sel < 45)      do_cpu(1'b0, a, 16'h0);
            else if (sel < 75) do_cpu(1'b1, a, v);
            else if (sel < 90) other_access(1'b0, a, 16'h0);
            else               other_access(1'b1, a, v);
        end
        finish_run();
    end
endmodule